// File: doc/BRIEF.md
# Monitor Result Serial Transmitter

This block sends per-window measurement results out of the chip on a three-wire serial link: a serial clock derived from the system clock, a frame sync, and a data line. Whenever the measurement logic raises its valid strobe, the block captures the power (20 bits), peak (13 bits) and threshold (13 bits) results. At the next opportunity it sends one frame. The frame holds only the fields whose enables are set, so its length follows the enables.

The serial clock is the system clock divided by 2, 4 or 8, chosen by a two-bit code. A sleep option stops the serial clock, holding it low, whenever there is nothing to send. A port enable gates the whole transmitter. A result that arrives while a frame is still on the wire waits in a one-entry slot. A later arrival overwrites that slot, so the newest result is always the next one sent.

The transmit controller has three states:
- `ST_IDLE`: no frame in flight.
- `ST_SYNC`: one serial-clock period with the frame sync high.
- `ST_SHIFT`: data bits go out.

All transitions happen at a serial-clock falling edge:
- *start*: `ST_IDLE`→`ST_SYNC`, when a result is pending and at least one field is enabled.
- *drop*: `ST_IDLE`→`ST_IDLE`, when a result is pending but no field is enabled; the result is consumed.
- *begin data*: `ST_SYNC`→`ST_SHIFT`.
- *next bit*: `ST_SHIFT`→`ST_SHIFT`, while bits remain.
- *chain*: `ST_SHIFT`→`ST_SYNC`, after the last bit when another result is pending.
- *finish*: `ST_SHIFT`→`ST_IDLE`, after the last bit when nothing is pending.
- *abort*: any state→`ST_IDLE`, one clock after the port enable goes low. This transition does not wait for a serial-clock edge.

Top module: `monres_serial_tx`

## Requirements
- R1: The serial clock period is 2 system clocks for divide code 01, 4 for code 10, 8 for code 11, and 2 for code 00.
- R2: With `sleep_en`=1, `sclk` stays low while no frame is in flight and no result is pending. With `sleep_en`=0, `sclk` toggles continuously.
- R3: With `port_en`=0 no frame is sent, arriving results are discarded, a frame in flight is aborted, and `fsync` and `sdo` are low. Nothing of an aborted frame is resent.
- R4: Each frame begins with `fsync` high for exactly one serial-clock period, the period just before the first data bit. `sdo` is low during that period, and `fsync` stays low during data bits.
- R5: A frame carries the enabled fields in the order power (20 bits, `pwr_en`), peak (13 bits, `pk_en`), threshold (13 bits, `thr_en`), each MSB first. Disabled fields are omitted, so the frame holds exactly the sum of the enabled widths.
- R6: While the port is enabled, `sdo` and `fsync` change only on the system clock edge on which `sclk` falls, so they are stable at every `sclk` rising edge.
- R7: A result whose capture finds no field enabled is consumed without sending a frame. Enabling fields afterwards does not send it.
- R8: A result that arrives while a frame is in flight is held and sent as the next frame.
- R9: Only one result is held. A newer arrival replaces an older pending one, and the older one is never sent.
- R10: During reset `sclk`, `fsync` and `sdo` are low, and no result is pending after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Transmitter enable |
| div_sel | input | 2 | Serial clock divide code |
| sleep_en | input | 1 | Park serial clock low when idle |
| pwr_en | input | 1 | Include power field |
| pk_en | input | 1 | Include peak field |
| thr_en | input | 1 | Include threshold field |
| res_valid | input | 1 | New result strobe, one clock |
| res_pwr | input | 20 | Power result |
| res_pk | input | 13 | Peak result |
| res_thr | input | 13 | Threshold result |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame sync |
| sdo | output | 1 | Serial data |

## Verification
The bench decodes the serial line as a receiver would: it samples `fsync` and `sdo` at every `sclk` rise and compares each frame with a bench-built expectation.

Random trials vary the divide code (including 00), the sleep option, the field-enable combination and the data. The enable mix tells field order and omission apart, the random data exposes bit-order slips, and the measured rise-to-rise spacing separates the divide codes.

Directed cases cover:
- a result sent while disabled;
- a result with every field off, followed by re-enabling;
- a single mid-frame arrival, which tells holding apart from dropping;
- two mid-frame arrivals, which tell newest-wins apart from oldest-wins;
- an abort mid-frame;
- a sleep window, where any `sclk` pulse is an error.

// File: rtl/monres_pkg.sv
package monres_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_e;

    // half of the serial clock period, in system clocks
    function automatic logic [3:0] half_period(input logic [1:0] code);
        unique case (code)
            2'b11:   half_period = 4'd4;
            2'b10:   half_period = 4'd2;
            default: half_period = 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/monres_sclk_gen.sv
module monres_sclk_gen
    import monres_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    input  logic       park,
    output logic       sclk,
    output logic       fall_tick
);
    localparam int CNT_W = 3;

    logic [CNT_W-1:0] cnt;
    logic             sclk_q;
    logic [3:0]       half;
    logic             wrap;

    assign half      = half_period(div_sel);
    assign wrap      = ({1'b0, cnt} >= (half - 4'd1));
    assign fall_tick = !park && wrap && sclk_q;
    assign sclk      = sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (park) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (wrap) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    // R2
    park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(park) |-> !sclk);

    // R1
    half_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt} < 4'd4);

endmodule

// File: rtl/monres_pend_slot.sv
module monres_pend_slot #(
    parameter int PW = 20,
    parameter int KW = 13,
    parameter int TW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_en,
    input  logic          res_valid,
    input  logic [PW-1:0] res_pwr,
    input  logic [KW-1:0] res_pk,
    input  logic [TW-1:0] res_thr,
    input  logic          take,
    output logic          pend_v,
    output logic [PW-1:0] pend_pwr,
    output logic [KW-1:0] pend_pk,
    output logic [TW-1:0] pend_thr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v   <= 1'b0;
            pend_pwr <= '0;
            pend_pk  <= '0;
            pend_thr <= '0;
        end else if (!port_en) begin
            pend_v   <= 1'b0;
        end else if (res_valid) begin
            pend_v   <= 1'b1;
            pend_pwr <= res_pwr;
            pend_pk  <= res_pk;
            pend_thr <= res_thr;
        end else if (take) begin
            pend_v   <= 1'b0;
        end
    end

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && port_en) |=> pend_v);

    // R3
    disabled_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !pend_v);

endmodule

// File: rtl/monres_frame_fsm.sv
module monres_frame_fsm
    import monres_pkg::*;
#(
    parameter int PW = 20,
    parameter int KW = 13,
    parameter int TW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_en,
    input  logic          fall_tick,
    input  logic          pwr_en,
    input  logic          pk_en,
    input  logic          thr_en,
    input  logic          pend_v,
    input  logic [PW-1:0] pend_pwr,
    input  logic [KW-1:0] pend_pk,
    input  logic [TW-1:0] pend_thr,
    output logic          take,
    output logic          idle_nodata,
    output logic          fsync,
    output logic          sdo
);
    localparam int FW = PW + KW + TW;
    localparam int LW = $clog2(FW + 1);

    tx_state_e      state, next_state;
    logic [FW-1:0]  shreg;
    logic [LW-1:0]  bits_left;
    logic           load;
    logic           any_en;
    logic [LW-1:0]  frame_len;
    logic [FW-1:0]  packed_acc;
    logic [FW-1:0]  frame_vec;

    assign any_en = pwr_en || pk_en || thr_en;

    // enabled fields packed power, peak, threshold, then left aligned
    always_comb begin
        packed_acc = '0;
        frame_len  = '0;
        if (pwr_en) begin
            packed_acc = (packed_acc << PW) | FW'(pend_pwr);
            frame_len  = frame_len + LW'(PW);
        end
        if (pk_en) begin
            packed_acc = (packed_acc << KW) | FW'(pend_pk);
            frame_len  = frame_len + LW'(KW);
        end
        if (thr_en) begin
            packed_acc = (packed_acc << TW) | FW'(pend_thr);
            frame_len  = frame_len + LW'(TW);
        end
        frame_vec = packed_acc << (LW'(FW) - frame_len);
    end

    always_comb begin
        next_state = state;
        take       = 1'b0;
        load       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (fall_tick && pend_v) begin
                    take = 1'b1;
                    if (any_en) begin
                        load       = 1'b1;
                        next_state = ST_SYNC;
                    end
                end
            end
            ST_SYNC: begin
                if (fall_tick) next_state = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (fall_tick && bits_left == LW'(1)) begin
                    if (pend_v) begin
                        take = 1'b1;
                        if (any_en) begin
                            load       = 1'b1;
                            next_state = ST_SYNC;
                        end else begin
                            next_state = ST_IDLE;
                        end
                    end else begin
                        next_state = ST_IDLE;
                    end
                end
            end
            default: next_state = ST_IDLE;
        endcase
        if (!port_en) begin
            next_state = ST_IDLE;
            take       = 1'b0;
            load       = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
        end else if (load) begin
            shreg     <= frame_vec;
            bits_left <= frame_len;
        end else if (state == ST_SHIFT && fall_tick && bits_left > LW'(1)) begin
            shreg     <= shreg << 1;
            bits_left <= bits_left - 1'b1;
        end
    end

    // outputs
    always_comb begin
        fsync       = (state == ST_SYNC);
        sdo         = (state == ST_SHIFT) ? shreg[FW-1] : 1'b0;
        idle_nodata = (state == ST_IDLE) && !pend_v;
    end

    // R4
    sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |-> !sdo);

    // R4
    sync_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && fall_tick && port_en) |=> (state == ST_SHIFT));

    // R5
    bits_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (bits_left != '0));

endmodule

// File: rtl/monres_serial_tx.sv
module monres_serial_tx
    import monres_pkg::*;
#(
    parameter int PW = 20,
    parameter int KW = 13,
    parameter int TW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_en,
    input  logic [1:0]    div_sel,
    input  logic          sleep_en,
    input  logic          pwr_en,
    input  logic          pk_en,
    input  logic          thr_en,
    input  logic          res_valid,
    input  logic [PW-1:0] res_pwr,
    input  logic [KW-1:0] res_pk,
    input  logic [TW-1:0] res_thr,
    output logic          sclk,
    output logic          fsync,
    output logic          sdo
);
    logic          fall_tick;
    logic          take;
    logic          idle_nodata;
    logic          park;
    logic          pend_v;
    logic [PW-1:0] pend_pwr;
    logic [KW-1:0] pend_pk;
    logic [TW-1:0] pend_thr;

    assign park = sleep_en && idle_nodata;

    monres_sclk_gen u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_sel   (div_sel),
        .park      (park),
        .sclk      (sclk),
        .fall_tick (fall_tick)
    );

    monres_pend_slot #(.PW(PW), .KW(KW), .TW(TW)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en   (port_en),
        .res_valid (res_valid),
        .res_pwr   (res_pwr),
        .res_pk    (res_pk),
        .res_thr   (res_thr),
        .take      (take),
        .pend_v    (pend_v),
        .pend_pwr  (pend_pwr),
        .pend_pk   (pend_pk),
        .pend_thr  (pend_thr)
    );

    monres_frame_fsm #(.PW(PW), .KW(KW), .TW(TW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_en     (port_en),
        .fall_tick   (fall_tick),
        .pwr_en      (pwr_en),
        .pk_en       (pk_en),
        .thr_en      (thr_en),
        .pend_v      (pend_v),
        .pend_pwr    (pend_pwr),
        .pend_pk     (pend_pk),
        .pend_thr    (pend_thr),
        .take        (take),
        .idle_nodata (idle_nodata),
        .fsync       (fsync),
        .sdo         (sdo)
    );

    // R6
    sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdo) && $past(port_en)) |-> $fell(sclk));

    // R6
    fsync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fsync) && $past(port_en)) |-> $fell(sclk));

endmodule

// File: tb/monres_serial_tx_tb.sv
module monres_serial_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 46;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic [1:0]  div_sel = 2'b01;
    logic        sleep_en = 1'b0;
    logic        pwr_en = 1'b1, pk_en = 1'b1, thr_en = 1'b1;
    logic        res_valid = 1'b0;
    logic [19:0] res_pwr = '0;
    logic [12:0] res_pk = '0;
    logic [12:0] res_thr = '0;
    logic        sclk, fsync, sdo;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    monres_serial_tx u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_sel(div_sel),
        .sleep_en(sleep_en), .pwr_en(pwr_en), .pk_en(pk_en), .thr_en(thr_en),
        .res_valid(res_valid), .res_pwr(res_pwr), .res_pk(res_pk),
        .res_thr(res_thr), .sclk(sclk), .fsync(fsync), .sdo(sdo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // receiver model
    int          exp_len = FW;
    logic [FW-1:0] cap [0:127];
    int          ncap = 0;
    int          nfs = 0;
    int          fs_err = 0;
    int          stray = 0;
    int          last_rise = 0;
    int          last_period = 0;
    int          rises = 0;
    bit          in_frame = 0;
    int          nbits = 0;
    logic [FW-1:0] got = '0;
    logic        psclk = 0, psdo = 0, pfs = 0, pen = 0;

    always @(negedge clk) begin
        if (rst_n && port_en && pen && (sdo !== psdo || fsync !== pfs) && !(psclk && !sclk))
            stray++;
        if (!port_en) in_frame = 0;
        if (!psclk && sclk) begin
            rises++;
            last_period = cyc - last_rise;
            last_rise = cyc;
            if (fsync) begin
                nfs++;
                if (in_frame || sdo) fs_err++;
                in_frame = 1; nbits = 0; got = '0;
            end else if (in_frame) begin
                got = {got[FW-2:0], sdo};
                nbits++;
                if (nbits == exp_len) begin
                    in_frame = 0;
                    cap[ncap] = got;
                    ncap++;
                end
            end
        end
        psclk = sclk; psdo = sdo; pfs = fsync; pen = port_en;
    end

    function automatic logic [FW-1:0] build(input logic e_p, input logic e_k,
            input logic e_t, input logic [19:0] p, input logic [12:0] k,
            input logic [12:0] t);
        logic [FW-1:0] v = '0;
        if (e_p) v = (v << 20) | FW'(p);
        if (e_k) v = (v << 13) | FW'(k);
        if (e_t) v = (v << 13) | FW'(t);
        return v;
    endfunction

    function automatic int flen(input logic e_p, input logic e_k, input logic e_t);
        return (e_p ? 20 : 0) + (e_k ? 13 : 0) + (e_t ? 13 : 0);
    endfunction

    function automatic int exp_period(input logic [1:0] d);
        return (d == 2'b11) ? 8 : (d == 2'b10) ? 4 : 2;
    endfunction

    task automatic check(input bit ok, input string req, input logic [FW-1:0] act,
            input logic [FW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [19:0] p, input logic [12:0] k, input logic [12:0] t);
        @(negedge clk);
        res_pwr = p; res_pk = k; res_thr = t; res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int base;
        int hi;
        void'($urandom(32'd7719));

        // R10: reset state
        idle(4);
        check(!sclk && !fsync && !sdo, "R10 outputs low in reset",
              FW'({sclk, fsync, sdo}), '0);
        rst_n = 1'b1;
        idle(40);
        check(ncap == 0 && nfs == 0, "R10 nothing sent after reset", FW'(nfs), '0);

        // R3: port disabled discards results
        send(20'hABCDE, 13'h1234, 13'h0F0F);
        idle(600);
        check(ncap == 0 && nfs == 0, "R3 no frame while disabled", FW'(nfs), '0);
        port_en = 1'b1;
        idle(600);
        check(ncap == 0, "R3 discarded result not sent later", FW'(ncap), '0);

        // R5 + R1 directed, all fields, divide by 2
        exp_len = 46;
        base = ncap;
        send(20'h80001, 13'h1001, 13'h0AAA);
        idle(300);
        check(ncap == base + 1, "R5 one frame", FW'(ncap - base), 1);
        check(cap[base] == build(1, 1, 1, 20'h80001, 13'h1001, 13'h0AAA),
              "R5 frame content", cap[base], build(1, 1, 1, 20'h80001, 13'h1001, 13'h0AAA));
        check(last_period == 2, "R1 code 01 period", FW'(last_period), 2);

        // random trials
        for (int i = 0; i < 24; i++) begin
            logic [1:0]  d;
            logic [2:0]  e;
            logic [19:0] p;
            logic [12:0] k, t;
            d = 2'($urandom); e = 3'($urandom);
            if (i < 3) e = 3'b111 >> i;
            p = 20'($urandom); k = 13'($urandom); t = 13'($urandom);
            @(negedge clk);
            div_sel = d; sleep_en = 1'($urandom);
            pwr_en = e[2]; pk_en = e[1]; thr_en = e[0];
            exp_len = flen(e[2], e[1], e[0]);
            idle(20);
            base = ncap;
            send(p, k, t);
            idle(500);
            if (e == 3'b000) begin
                check(ncap == base, "R7 no frame without fields", FW'(ncap - base), 0);
            end else begin
                check(ncap == base + 1 && cap[base] == build(e[2], e[1], e[0], p, k, t),
                      "R5 random frame", cap[base], build(e[2], e[1], e[0], p, k, t));
                check(last_period == exp_period(d), "R1 random divide",
                      FW'(last_period), FW'(exp_period(d)));
            end
        end

        // R7: result dropped with no fields, not revived by enabling
        div_sel = 2'b01; sleep_en = 1'b0;
        pwr_en = 0; pk_en = 0; thr_en = 0;
        base = ncap;
        send(20'h12345, 13'h0111, 13'h0222);
        idle(20);
        pwr_en = 1; pk_en = 1; thr_en = 1; exp_len = 46;
        idle(400);
        check(ncap == base, "R7 consumed without frame", FW'(ncap - base), 0);

        // R2: sleep parks clock low
        sleep_en = 1'b1;
        idle(30);
        hi = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (sclk) hi++;
        end
        check(hi == 0, "R2 sclk parked low", FW'(hi), 0);
        sleep_en = 1'b0;
        idle(4);
        base = rises;
        idle(60);
        check(rises - base >= 25, "R2 sclk free runs", FW'(rises - base), 30);

        // R8: one arrival during frame is held
        div_sel = 2'b11;
        base = ncap;
        send(20'h11111, 13'h0101, 13'h0202);
        idle(60);
        send(20'h22222, 13'h0303, 13'h0404);
        idle(900);
        check(ncap == base + 2 && cap[base + 1] == build(1, 1, 1, 20'h22222, 13'h0303, 13'h0404),
              "R8 held result sent next", cap[base + 1],
              build(1, 1, 1, 20'h22222, 13'h0303, 13'h0404));

        // R9: newest pending replaces older
        base = ncap;
        send(20'hAAAAA, 13'h0AAA, 13'h1555);
        idle(60);
        send(20'hBBBBB, 13'h0BBB, 13'h0BBB);
        idle(60);
        send(20'hCCCCC, 13'h0CCC, 13'h0CCC);
        idle(900);
        check(ncap == base + 2, "R9 two frames", FW'(ncap - base), 2);
        check(cap[base] == build(1, 1, 1, 20'hAAAAA, 13'h0AAA, 13'h1555),
              "R9 first frame", cap[base], build(1, 1, 1, 20'hAAAAA, 13'h0AAA, 13'h1555));
        check(cap[base + 1] == build(1, 1, 1, 20'hCCCCC, 13'h0CCC, 13'h0CCC),
              "R9 newest wins", cap[base + 1], build(1, 1, 1, 20'hCCCCC, 13'h0CCC, 13'h0CCC));

        // R3: abort mid-frame
        base = ncap;
        send(20'h5A5A5, 13'h1A1A, 13'h0505);
        idle(100);
        port_en = 1'b0;
        idle(3);
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (fsync || sdo) hi++;
        end
        check(hi == 0, "R3 outputs quiet when disabled", FW'(hi), 0);
        port_en = 1'b1;
        idle(800);
        check(ncap == base, "R3 aborted frame not resent", FW'(ncap - base), 0);

        check(fs_err == 0, "R4 sync pulse shape", FW'(fs_err), 0);
        check(stray == 0, "R6 changes only at sclk fall", FW'(stray), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule